// File: doc/BRIEF.md
# MFM Raw Sync Mark Detector and Field Decoder

This block sits behind a floppy data separator. It receives one recovered MFM cell per `cell_valid` cycle and hunts for a sector-ID mark or a data mark. Each mark is a 32-cell raw pattern that holds a flux gap longer than any legal MFM run. Because of that gap, a mark can never appear inside encoded data. While hunting, every cell is shifted into a window. The window is compared against two configurable raw patterns.

After a match, the block takes the following cells as clock/data pairs. It builds bytes from the data cells and emits each byte with a one-cycle strobe. It runs a CCITT-style 16-bit CRC over the field and flags the result when the field ends. An ID field has a fixed length set by a parameter. A data field takes its length from `rec_len`, which is sampled at the mark, because record size differs from track to track. The decoded stream is also compared against two configurable 32-bit mark words, and a match is reported with its type.

Top module: `mfm_mark_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears every strobe and `crc_ok`, returns the block to hunting, and reloads the four configuration registers with their defaults (raw address 0x55509255, raw data 0x55509251, word address 0x55424954, word data 0x55424945).
- R2: The window takes the first-received cell as its MSB. When the window equals the raw address pattern, `mark_stb` is high in the cycle after the cell that completed it, with `mark_type` = 0.
- R3: When the window equals the raw data pattern, `mark_stb` is high one cycle after the completing cell, with `mark_type` = 1. If both patterns match, the address mark wins.
- R4: After a mark, the cells alternate clock, data, clock, data, starting with a clock cell. Each byte is built MSB first from eight data cells. `byte_stb` and `byte_data` appear one cycle after the sixteenth cell of the byte.
- R5: A data field is `rec_len` bytes long, counting the two CRC bytes. The length is sampled at the data mark, and 0 is treated as 1. After the last byte the block hunts again, and later encoded cells produce no `byte_stb`.
- R6: An ID field is ID_LEN bytes long, counting its CRC bytes (default 6).
- R7: The CRC uses polynomial 0x1021 and is preset to 0xFFFF at the mark. It is fed MSB first over every byte of the field. `field_stb` marks the last byte and carries `field_type`. `crc_ok` is 1 exactly when the remainder is zero, and it holds until the next mark.
- R8: A mark match while a field is being decoded drops that field and restarts alignment, count and CRC for the new mark.
- R9: When the last four decoded bytes of the current field equal the word-address register, `word_stb` goes high with `word_type` = 0. When they equal the word-data register, `word_type` = 1. Both come in the same cycle as the `byte_stb` of the completing byte.
- R10: A `cfg_wr` pulse loads `cfg_data` into the register picked by `cfg_sel`: 0 raw address, 1 raw data, 2 word address, 3 word data. The new value applies from the next cell on.
- R11: A reset in the middle of a field abandons it. No further bytes come out until a new mark arrives.
- R12: Cycles with `cell_valid` low change no state, so idle cycles inside a mark or a byte do not alter the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_valid | input | 1 | A recovered cell is present this cycle |
| cell_bit | input | 1 | Value of the recovered cell |
| rec_len | input | CNT_W | Data field length in bytes, including CRC |
| cfg_wr | input | 1 | Write strobe for a configuration register |
| cfg_sel | input | 2 | Selects the configuration register to write |
| cfg_data | input | WIN_W | Value to write |
| mark_stb | output | 1 | A raw mark was detected |
| mark_type | output | 1 | 0 address mark, 1 data mark |
| byte_stb | output | 1 | A decoded byte is valid |
| byte_data | output | BYTE_W | Decoded byte |
| field_stb | output | 1 | Last byte of a field |
| field_type | output | 1 | Type of the field that ended |
| crc_ok | output | 1 | CRC remainder of the last field was zero |
| word_stb | output | 1 | Decoded word matched a mark word |
| word_type | output | 1 | 0 address word, 1 data word |

## Verification
The bench uses the default parameters: a 32-cell window, 8-bit bytes, 32-bit mark words, a 16-bit length counter and a 6-byte ID field. Payloads are short, so every data length from 3 to 22 bytes is reachable. Each run therefore covers the smallest data fields, and a mark can be made to land part-way through another field. The 32-cell raw patterns match the defaults of the configuration registers, so rewriting a register and resetting back to the defaults can both be watched through the mark strobe.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

   typedef enum logic {
      MK_ADDR = 1'b0,
      MK_DATA = 1'b1
   } mark_kind_e;

   // one bit of a left-shifting CRC
   function automatic logic [15:0] crc_bit_step(input logic [15:0] cur,
                                                input logic        din,
                                                input logic [15:0] poly);
      logic fb;
      fb = cur[15] ^ din;
      return {cur[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
   endfunction

endpackage

// File: rtl/mfm_raw_matcher.sv
module mfm_raw_matcher #(
   parameter int WIN_W   = 32,
   parameter int NUM_PAT = 2
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              cell_valid,
   input  logic                              cell_bit,
   input  logic [NUM_PAT-1:0][WIN_W-1:0]     pats,
   output logic [NUM_PAT-1:0]                hits
);

   logic [WIN_W-1:0] win;
   logic [WIN_W-1:0] win_nx;

   assign win_nx = {win[WIN_W-2:0], cell_bit};

   generate
      for (genvar g = 0; g < NUM_PAT; g++) begin : g_cmp
         assign hits[g] = cell_valid && (win_nx == pats[g]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         win <= '0;
      else if (cell_valid)
         win <= win_nx;
   end

   // R12: the window only moves on a valid cell
   p_win_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (!cell_valid && !rst) |=> $stable(win));

endmodule

// File: rtl/mfm_cell_deser.sv
module mfm_cell_deser #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              en,
   input  logic              cell_bit,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);

   localparam int CELLS = 2 * BYTE_W;
   localparam int IDX_W = $clog2(CELLS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(CELLS - 1);

   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-2:0] sr;

   generate
      if (BYTE_W < 3) begin : g_bad_w
         $error("mfm_cell_deser: BYTE_W must be at least 3");
      end
   endgenerate

   assign byte_done = en && (idx == LAST);
   assign byte_val  = {sr, cell_bit};

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         idx <= '0;
         sr  <= '0;
      end else if (en) begin
         idx <= (idx == LAST) ? '0 : idx + 1'b1;
         if (idx[0])
            sr <= {sr[BYTE_W-3:0], cell_bit};
      end
   end

   // R12: cell position only advances on an accepted cell
   p_idx_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (!en && !clr && !rst) |=> $stable(idx));

endmodule

// File: rtl/mfm_crc16.sv
module mfm_crc16 #(
   parameter int          DIN_W  = 8,
   parameter logic [15:0] POLY   = 16'h1021,
   parameter logic [15:0] PRESET = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             init,
   input  logic             en,
   input  logic [DIN_W-1:0] din,
   output logic [15:0]      crc_nx
);
   import mfm_pkg::*;

   logic [15:0] crc_q;

   always_comb begin
      crc_nx = crc_q;
      for (int i = DIN_W - 1; i >= 0; i--)
         crc_nx = crc_bit_step(crc_nx, din[i], POLY);
   end

   always_ff @(posedge clk) begin
      if (rst || init)
         crc_q <= PRESET;
      else if (en)
         crc_q <= crc_nx;
   end

endmodule

// File: rtl/mfm_mark_decoder.sv
module mfm_mark_decoder #(
   parameter int               WIN_W          = 32,
   parameter int               BYTE_W         = 8,
   parameter int               WORD_W         = 32,
   parameter int               CNT_W          = 16,
   parameter int               ID_LEN         = 6,
   parameter logic [15:0]      CRC_POLY       = 16'h1021,
   parameter logic [15:0]      CRC_PRESET     = 16'hFFFF,
   parameter logic [WIN_W-1:0] RAW_ADDR_INIT  = 32'h55509255,
   parameter logic [WIN_W-1:0] RAW_DATA_INIT  = 32'h55509251,
   parameter logic [WORD_W-1:0] WORD_ADDR_INIT = 32'h55424954,
   parameter logic [WORD_W-1:0] WORD_DATA_INIT = 32'h55424945
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cell_valid,
   input  logic              cell_bit,
   input  logic [CNT_W-1:0]  rec_len,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [WIN_W-1:0]  cfg_data,
   output logic              mark_stb,
   output logic              mark_type,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_data,
   output logic              field_stb,
   output logic              field_type,
   output logic              crc_ok,
   output logic              word_stb,
   output logic              word_type
);
   import mfm_pkg::*;

   localparam int HIST_W = WORD_W - BYTE_W;
   localparam logic [CNT_W-1:0] ID_LEN_C = CNT_W'(ID_LEN);

   generate
      if (WIN_W < 16 || (WIN_W % 2) != 0) begin : g_bad_win
         $error("mfm_mark_decoder: WIN_W must be even and at least 16");
      end
      if ((WORD_W % BYTE_W) != 0 || WORD_W <= BYTE_W || WORD_W > WIN_W) begin : g_bad_word
         $error("mfm_mark_decoder: WORD_W must be a multiple of BYTE_W, above it, and not above WIN_W");
      end
      if (ID_LEN < 3 || ID_LEN >= (1 << CNT_W)) begin : g_bad_id
         $error("mfm_mark_decoder: ID_LEN out of range");
      end
   endgenerate

   // configuration
   logic [1:0][WIN_W-1:0]  raw_pat;
   logic [1:0][WORD_W-1:0] word_pat;

   // field control
   logic              busy;
   mark_kind_e        fkind;
   logic [CNT_W-1:0]  field_len;
   logic [CNT_W-1:0]  byte_cnt;
   logic [HIST_W-1:0] hist;

   // datapath links
   logic [1:0]        raw_hits;
   logic              mark_hit;
   mark_kind_e        hit_kind;
   logic              deser_en;
   logic              byte_done;
   logic [BYTE_W-1:0] byte_val;
   logic [15:0]       crc_nx;
   logic [WORD_W-1:0] word_nx;
   logic [1:0]        word_hits;
   logic              last_byte;
   logic [CNT_W-1:0]  data_len;

   mfm_raw_matcher #(.WIN_W(WIN_W), .NUM_PAT(2)) u_match (
      .clk        (clk),
      .rst        (rst),
      .cell_valid (cell_valid),
      .cell_bit   (cell_bit),
      .pats       (raw_pat),
      .hits       (raw_hits)
   );

   assign mark_hit = |raw_hits;
   assign hit_kind = raw_hits[0] ? MK_ADDR : MK_DATA;
   assign deser_en = cell_valid && busy && !mark_hit;

   mfm_cell_deser #(.BYTE_W(BYTE_W)) u_deser (
      .clk       (clk),
      .rst       (rst),
      .clr       (mark_hit),
      .en        (deser_en),
      .cell_bit  (cell_bit),
      .byte_done (byte_done),
      .byte_val  (byte_val)
   );

   mfm_crc16 #(.DIN_W(BYTE_W), .POLY(CRC_POLY), .PRESET(CRC_PRESET)) u_crc (
      .clk    (clk),
      .rst    (rst),
      .init   (mark_hit),
      .en     (byte_done),
      .din    (byte_val),
      .crc_nx (crc_nx)
   );

   assign word_nx = {hist, byte_val};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_word
         assign word_hits[g] = (word_nx == word_pat[g]);
      end
   endgenerate

   assign last_byte = (byte_cnt + 1'b1) == field_len;
   assign data_len  = (rec_len == '0) ? CNT_W'(1) : rec_len;

   always_ff @(posedge clk) begin
      if (rst) begin
         raw_pat[0]  <= RAW_ADDR_INIT;
         raw_pat[1]  <= RAW_DATA_INIT;
         word_pat[0] <= WORD_ADDR_INIT;
         word_pat[1] <= WORD_DATA_INIT;
      end else if (cfg_wr) begin
         case (cfg_sel)
            2'd0:    raw_pat[0]  <= cfg_data;
            2'd1:    raw_pat[1]  <= cfg_data;
            2'd2:    word_pat[0] <= cfg_data[WORD_W-1:0];
            default: word_pat[1] <= cfg_data[WORD_W-1:0];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy       <= 1'b0;
         fkind      <= MK_ADDR;
         field_len  <= ID_LEN_C;
         byte_cnt   <= '0;
         hist       <= '0;
         mark_stb   <= 1'b0;
         mark_type  <= 1'b0;
         byte_stb   <= 1'b0;
         byte_data  <= '0;
         field_stb  <= 1'b0;
         field_type <= 1'b0;
         crc_ok     <= 1'b0;
         word_stb   <= 1'b0;
         word_type  <= 1'b0;
      end else begin
         mark_stb  <= 1'b0;
         byte_stb  <= 1'b0;
         field_stb <= 1'b0;
         word_stb  <= 1'b0;
         if (mark_hit) begin
            mark_stb  <= 1'b1;
            mark_type <= hit_kind;
            busy      <= 1'b1;
            fkind     <= hit_kind;
            field_len <= (hit_kind == MK_ADDR) ? ID_LEN_C : data_len;
            byte_cnt  <= '0;
            hist      <= '0;
            crc_ok    <= 1'b0;
         end else if (byte_done) begin
            byte_stb  <= 1'b1;
            byte_data <= byte_val;
            hist      <= word_nx[HIST_W-1:0];
            byte_cnt  <= byte_cnt + 1'b1;
            if (|word_hits) begin
               word_stb  <= 1'b1;
               word_type <= !word_hits[0];
            end
            if (last_byte) begin
               busy       <= 1'b0;
               field_stb  <= 1'b1;
               field_type <= fkind;
               crc_ok     <= (crc_nx == 16'h0000);
            end
         end
      end
   end

   // R1: first cycle after reset is quiet and hunting
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!busy && !byte_stb && !mark_stb && !field_stb));

   // R4: bytes only come out of an open field
   p_byte_in_field_r4: assert property (@(posedge clk) disable iff (rst)
      byte_stb |-> $past(busy));

   // R5: the count never reaches the field length while open
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
      busy |-> (byte_cnt < field_len));

   // R5: a finished field leaves the block hunting
   p_field_end_idle_r5: assert property (@(posedge clk) disable iff (rst)
      field_stb |-> (!busy && byte_stb));

   // R8: a mark takes precedence over a byte on the same cell
   p_mark_wins_r8: assert property (@(posedge clk) disable iff (rst)
      mark_stb |-> (!byte_stb && !field_stb && busy));

   // R9: a word hit accompanies a decoded byte
   p_word_with_byte_r9: assert property (@(posedge clk) disable iff (rst)
      word_stb |-> byte_stb);

endmodule

// File: tb/sim_mfm_mark_decoder.sv
module sim_mfm_mark_decoder;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RAW_A  = 32'h55509255;
   localparam logic [31:0] RAW_D  = 32'h55509251;
   localparam logic [31:0] RAW_A2 = 32'h55509249;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cell_valid = 1'b0;
   logic        cell_bit = 1'b0;
   logic [15:0] rec_len = 16'd8;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_data = '0;
   logic        mark_stb, mark_type, byte_stb, field_stb, field_type;
   logic        crc_ok, word_stb, word_type;
   logic [7:0]  byte_data;

   int   nchk = 0;
   int   nfail = 0;
   int   seen_bytes = 0;
   bit   gap_en = 1'b0;
   bit   finished = 1'b0;
   logic prev_d = 1'b0;
   logic [7:0] fbuf [0:63];
   int   word_idx;
   logic word_kind;

   always #(CLK_PERIOD/2) clk = ~clk;

   mfm_mark_decoder u0 (
      .clk(clk), .rst(rst), .cell_valid(cell_valid), .cell_bit(cell_bit),
      .rec_len(rec_len), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .mark_stb(mark_stb), .mark_type(mark_type), .byte_stb(byte_stb),
      .byte_data(byte_data), .field_stb(field_stb), .field_type(field_type),
      .crc_ok(crc_ok), .word_stb(word_stb), .word_type(word_type)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < n; k++)
         for (int b = 7; b >= 0; b--)
            c = ((c[15] ^ fbuf[k][b]) != 1'b0) ? ({c[14:0], 1'b0} ^ 16'h1021)
                                                 : {c[14:0], 1'b0};
      return c;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   // one cell, optionally preceded by an idle cycle; outputs read at negedge
   task automatic tick_cell(input logic b);
      if (gap_en && ($urandom % 8) == 0) begin
         cell_valid = 1'b0;
         @(posedge clk);
         @(negedge clk);
         chk(!(mark_stb || byte_stb || field_stb), "R12", "strobe on idle cycle",
             {29'd0, mark_stb, byte_stb, field_stb}, 32'd0);
      end
      cell_valid = 1'b1;
      cell_bit   = b;
      @(posedge clk);
      @(negedge clk);
      cell_valid = 1'b0;
      if (byte_stb) seen_bytes++;
   endtask

   task automatic send_raw(input logic [31:0] w);
      for (int i = 31; i >= 0; i--) tick_cell(w[i]);
      prev_d = w[0];
   endtask

   task automatic send_byte(input logic [7:0] b, input bit expect_byte);
      for (int i = 7; i >= 0; i--) begin
         tick_cell(~(prev_d | b[i]));
         tick_cell(b[i]);
         prev_d = b[i];
      end
      if (expect_byte)
         chk(byte_stb && byte_data == b, "R4", "decoded byte",
             {23'd0, byte_stb, byte_data}, {24'd1, b});
   endtask

   // payload of n bytes in fbuf; CRC appended; kind 0 address, 1 data
   task automatic send_field(input bit kind, input int n, input bit corrupt);
      logic [15:0] c;
      c = ref_crc(n);
      fbuf[n]   = c[15:8];
      fbuf[n+1] = c[7:0] ^ (corrupt ? 8'h01 : 8'h00);
      if (kind) rec_len = 16'(n + 2);
      word_idx = -1;
      send_raw(kind ? RAW_D : RAW_A);
      chk(mark_stb && mark_type == kind, kind ? "R3" : "R2", "mark strobe/type",
          {30'd0, mark_stb, mark_type}, {30'd0, 1'b1, kind});
      for (int k = 0; k < n + 2; k++) begin
         send_byte(fbuf[k], 1'b1);
         if (word_stb) begin word_idx = k; word_kind = word_type; end
         if (k < n + 1)
            chk(!field_stb, kind ? "R5" : "R6", "early field end", {31'd0, field_stb}, 32'd0);
      end
      chk(field_stb && field_type == kind, kind ? "R5" : "R6", "field end",
          {30'd0, field_stb, field_type}, {30'd0, 1'b1, kind});
      chk(crc_ok == !corrupt, "R7", "crc flag", {31'd0, crc_ok}, {31'd0, !corrupt});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic write_cfg(input logic [1:0] sel, input logic [31:0] val);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_data = val;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base;
      void'($urandom(32'd20417));
      do_reset();
      // R1: reset state
      chk(!(mark_stb || byte_stb || field_stb || word_stb || crc_ok), "R1", "reset outputs",
          {27'd0, mark_stb, byte_stb, field_stb, word_stb, crc_ok}, 32'd0);

      // R2 R6 R7: ID field
      send_byte(8'h00, 1'b0); send_byte(8'h4E, 1'b0);
      for (int k = 0; k < 4; k++) fbuf[k] = 8'($urandom);
      send_field(1'b0, 4, 1'b0);

      // R3 R5: data field, then trailing cells give nothing
      for (int k = 0; k < 10; k++) fbuf[k] = 8'($urandom);
      send_field(1'b1, 10, 1'b0);
      base = seen_bytes;
      send_byte(8'hA5, 1'b0); send_byte(8'h3C, 1'b0);
      chk(seen_bytes == base, "R5", "bytes after field end", 32'(seen_bytes - base), 32'd0);

      // R5: shortest data field (payload of one byte)
      fbuf[0] = 8'hC3;
      send_field(1'b1, 1, 1'b0);

      // R7: corrupted CRC
      for (int k = 0; k < 4; k++) fbuf[k] = 8'($urandom);
      send_field(1'b0, 4, 1'b1);

      // R9: decoded mark words
      fbuf[0] = 8'h11; fbuf[1] = 8'h55; fbuf[2] = 8'h42; fbuf[3] = 8'h49; fbuf[4] = 8'h54;
      fbuf[5] = 8'h00;
      send_field(1'b1, 6, 1'b0);
      chk(word_idx == 4 && word_kind == 1'b0, "R9", "address word hit index/type",
          {word_idx[30:0], word_kind}, {31'd4, 1'b0});
      fbuf[0] = 8'h55; fbuf[1] = 8'h42; fbuf[2] = 8'h49; fbuf[3] = 8'h45;
      send_field(1'b1, 4, 1'b0);
      chk(word_idx == 3 && word_kind == 1'b1, "R9", "data word hit index/type",
          {word_idx[30:0], word_kind}, {31'd3, 1'b1});

      // R8: mark during an open field restarts decoding
      rec_len = 16'd40;
      send_raw(RAW_D);
      send_byte(8'h12, 1'b1); send_byte(8'h34, 1'b1);
      for (int k = 0; k < 4; k++) fbuf[k] = 8'($urandom);
      send_field(1'b0, 4, 1'b0);
      chk(1'b1, "R8", "restart completed", 32'd0, 32'd0);

      // R12: long idle stretch inside a byte
      send_raw(RAW_A);
      chk(mark_stb && mark_type == 1'b0, "R2", "mark before idle test",
          {31'd0, mark_stb}, 32'd1);
      fbuf[0] = 8'hB7;
      for (int i = 7; i >= 4; i--) begin
         tick_cell(~(prev_d | fbuf[0][i])); tick_cell(fbuf[0][i]); prev_d = fbuf[0][i];
      end
      cell_valid = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      for (int i = 3; i >= 0; i--) begin
         tick_cell(~(prev_d | fbuf[0][i])); tick_cell(fbuf[0][i]); prev_d = fbuf[0][i];
      end
      chk(byte_stb && byte_data == 8'hB7, "R12", "byte across idle gap",
          {23'd0, byte_stb, byte_data}, {24'd1, 8'hB7});

      // R11: reset mid-field
      do_reset();
      base = seen_bytes;
      send_byte(8'h77, 1'b0); send_byte(8'h88, 1'b0);
      chk(seen_bytes == base, "R11", "bytes after reset", 32'(seen_bytes - base), 32'd0);

      // R10: reprogram the raw address pattern
      write_cfg(2'd0, RAW_A2);
      send_raw(RAW_A);
      chk(!mark_stb, "R10", "old pattern still detected", {31'd0, mark_stb}, 32'd0);
      base = seen_bytes;
      send_byte(8'h5A, 1'b0);
      chk(seen_bytes == base, "R10", "bytes after old pattern", 32'(seen_bytes - base), 32'd0);
      send_raw(RAW_A2);
      chk(mark_stb && mark_type == 1'b0, "R10", "new pattern", {31'd0, mark_stb}, 32'd1);
      for (int k = 0; k < 6; k++) send_byte(8'(k * 37), 1'b1);
      // R10: reprogram the decoded address word
      write_cfg(2'd2, 32'hDEADBEEF);
      fbuf[0] = 8'hDE; fbuf[1] = 8'hAD; fbuf[2] = 8'hBE; fbuf[3] = 8'hEF;
      send_field(1'b1, 4, 1'b0);
      chk(word_idx == 3 && word_kind == 1'b0, "R10", "new word", {word_idx[30:0], word_kind},
          {31'd3, 1'b0});

      // R1: reset restores default patterns
      do_reset();
      send_raw(RAW_A);
      chk(mark_stb && mark_type == 1'b0, "R1", "default pattern after reset",
          {31'd0, mark_stb}, 32'd1);
      do_reset();

      // random fields with idle gaps
      gap_en = 1'b1;
      for (int it = 0; it < 40; it++) begin
         bit kind;
         int n;
         kind = 1'($urandom);
         n = kind ? 1 + int'($urandom % 20) : 4;
         for (int p = 0; p < int'($urandom % 4); p++) send_byte(8'($urandom), 1'b0);
         for (int k = 0; k < n; k++) fbuf[k] = 8'($urandom);
         send_field(kind, n, ($urandom % 4) == 0);
         base = seen_bytes;
         send_byte(8'($urandom), 1'b0);
         chk(seen_bytes == base, "R5", "random trailer", 32'(seen_bytes - base), 32'd0);
      end
      finish_run();
   end
endmodule